// File: doc/BRIEF.md
# Decimal Paged Address Translator

This block maps the addresses of a small accumulator machine whose memory holds one hundred words, numbered 0 to 99 in decimal. Memory is divided into ten pages of ten words, and each page is named by its first address (00, 10, ... 90). The tens digit of an address selects the page and the units digit selects the word within it. In kernel mode an address passes through unchanged. In user mode the block looks up the page in a per-process page map and returns the physical address, which is the mapped page base plus the offset.

Each process keeps its page map in its own data page. Map words 0 to 7 hold the page base for virtual pages 0 to 7. Words 8 and 9 hold saved state, so they are never used as mappings. The base of the map page for each process number is set by a parameter table. The block reads one map word through a memory read port that has one cycle of latency.

A negative map entry means the page is on secondary storage. In that case the block reports a page fault, gives the faulting virtual page, and names the user frame loaded longest ago as the one to replace. The three user frames are 70, 80 and 90. The block then waits for a fault-done pulse, moves its oldest-frame pointer on to the next frame, and repeats the lookup.

Top module: `dec_page_xlate`

## Requirements
- R1: An in-range kernel-mode request (`req_user`=0) gives `rsp_valid` in the cycle after it is accepted. `rsp_paddr` equals `req_addr`, `rsp_err` and `rsp_fault` are 0, and no memory read is issued.
- R2: A request whose address is 100 or more gives `rsp_err`=1 in the cycle after acceptance, in either mode, and no memory read is issued.
- R3: In user mode the block reads the map entry and returns `rsp_paddr` = entry + (address mod 10). `rsp_valid` comes in the second cycle after the read cycle.
- R4: A user lookup issues exactly one read in the cycle after acceptance, at address base(pid) + (address div 10). The base is 40 for pid 1, 50 for pid 2 and 60 for pid 3.
- R5: A negative map entry gives `rsp_fault`=1 with `rsp_vpage` set to the tens digit and `rsp_victim` set to the current oldest frame. `req_ready` then stays low until `fault_done`.
- R6: A `fault_done` pulse advances the oldest frame in the order 70, 80, 90, 70. In the cycle after the pulse, the same map read is issued again and the request completes as in R3.
- R7: A user request to virtual page 8 or 9 gives `rsp_err`=1 in the cycle after acceptance, with no memory read.
- R8: A non-negative map entry that is above 90 or is not a multiple of 10 gives `rsp_err`=1 and `rsp_fault`=0.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd_en`=0, and the first fault names victim frame 70.
- R10: `rsp_valid` is a one-cycle pulse for each request. `req_ready` is low from acceptance until the block returns to idle.
- R11: A user-mode request with pid 0 gives `rsp_err`=1 in the cycle after acceptance, with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 7 | Address, binary, 0 to 99 |
| req_user | input | 1 | 1 = user mode (translate), 0 = kernel mode (pass through) |
| req_pid | input | 2 | Process number, 1 to 3 |
| mem_rd_en | output | 1 | Map read strobe |
| mem_rd_addr | output | 7 | Map word address |
| mem_rd_data | input | 16 | Signed map entry, valid one cycle after the strobe |
| fault_done | input | 1 | Pulse: the page fault has been serviced |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 7 | Physical address |
| rsp_fault | output | 1 | Page fault |
| rsp_vpage | output | 4 | Faulting virtual page |
| rsp_victim | output | 7 | Base of the frame to replace |
| rsp_err | output | 1 | Address error |

## Verification
Kernel requests, out-of-range addresses, pid 0 and pages 8 or 9 all produce their response one cycle after acceptance. A lookup instead puts its read on the port in that first cycle, shows no response in the second cycle, and responds in the third cycle. Each scenario task drives its inputs on falling edges and samples the outputs on falling edges at exactly those offsets. The task also checks that `rsp_valid` has dropped and that `req_ready` has returned on the following falling edge. After a fault, the replayed read is expected one cycle after the `fault_done` edge, and its response two cycles later. Four faults in a row check that the victim order wraps.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int PAGE_WORDS = 10;
  localparam int NUM_PAGES  = 10;
  localparam int MEM_LIMIT  = PAGE_WORDS * NUM_PAGES;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FAULT  = 2'd3
  } dpx_state_e;
endpackage

// File: rtl/dpx_rst_sync.sv
module dpx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dpx_digit_split.sv
module dpx_digit_split
  import dpx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        tens,
  output logic [3:0]        units,
  output logic              in_range
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_LIMIT);
  localparam logic [ADDR_W-1:0] TEN   = ADDR_W'(PAGE_WORDS);

  always_comb begin
    in_range = (addr < LIMIT);
    tens     = 4'(addr / TEN);
    units    = 4'(addr % TEN);
  end
endmodule

// File: rtl/dpx_entry_check.sv
module dpx_entry_check
  import dpx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic [DATA_W-1:0] entry,
  output logic              swapped,
  output logic              malformed,
  output logic [ADDR_W-1:0] frame_base
);
  localparam logic [DATA_W-1:0] TOP_BASE = DATA_W'(MEM_LIMIT - PAGE_WORDS);
  localparam logic [DATA_W-1:0] TEN      = DATA_W'(PAGE_WORDS);

  always_comb begin
    swapped    = entry[DATA_W-1];
    malformed  = !swapped && ((entry > TOP_BASE) || ((entry % TEN) != '0));
    frame_base = entry[ADDR_W-1:0];
  end
endmodule

// File: rtl/dpx_victim_ring.sv
module dpx_victim_ring
  import dpx_pkg::*;
#(
  parameter int N_FRAMES    = 3,
  parameter int FIRST_FRAME = 7,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [ADDR_W-1:0] victim_base
);
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance) idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign victim_base = ADDR_W'((FIRST_FRAME + int'(idx_q)) * PAGE_WORDS);

  // R6
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R6
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (victim_base != $past(victim_base)));
endmodule

// File: rtl/dec_page_xlate.sv
module dec_page_xlate
  import dpx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PID_W       = 2,
  parameter int MAP_SLOTS   = 8,
  parameter int N_FRAMES    = 3,
  parameter int FIRST_FRAME = 7,
  parameter logic [(2**PID_W)*ADDR_W-1:0] MAP_BASE_TBL =
    {7'd60, 7'd50, 7'd40, 7'd0}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_user,
  input  logic [PID_W-1:0]  req_pid,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              fault_done,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [3:0]        rsp_vpage,
  output logic [ADDR_W-1:0] rsp_victim,
  output logic              rsp_err
);
  localparam logic [3:0] MAP_LIMIT = 4'(MAP_SLOTS);

  logic srst_n;
  dpx_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  // address digits
  logic [3:0] in_tens, in_units;
  logic       in_range;
  dpx_digit_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(req_addr), .tens(in_tens), .units(in_units), .in_range(in_range)
  );

  // map entry check
  logic              ent_swapped, ent_bad;
  logic [ADDR_W-1:0] ent_base;
  dpx_entry_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_check (
    .entry(mem_rd_data), .swapped(ent_swapped), .malformed(ent_bad),
    .frame_base(ent_base)
  );

  // oldest-frame tracker
  logic              ring_adv;
  logic [ADDR_W-1:0] oldest_base;
  dpx_victim_ring #(.N_FRAMES(N_FRAMES), .FIRST_FRAME(FIRST_FRAME),
                    .ADDR_W(ADDR_W)) u_ring (
    .clk(clk), .rst_n(srst_n), .advance(ring_adv), .victim_base(oldest_base)
  );

  dpx_state_e        state_q, state_d;
  logic [3:0]        vpage_q, units_q;
  logic [PID_W-1:0]  pid_q;
  logic              ctx_load;

  logic              rsp_load;
  logic [ADDR_W-1:0] paddr_d;
  logic              fault_d, err_d;
  logic [3:0]        vpage_d;
  logic [ADDR_W-1:0] victim_d;

  logic              accept;
  logic [ADDR_W-1:0] map_base;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign map_base  = MAP_BASE_TBL[pid_q*ADDR_W +: ADDR_W];

  // next-state and response selection
  always_comb begin
    state_d     = state_q;
    ctx_load    = 1'b0;
    rsp_load    = 1'b0;
    paddr_d     = '0;
    fault_d     = 1'b0;
    err_d       = 1'b0;
    vpage_d     = '0;
    victim_d    = '0;
    ring_adv    = 1'b0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!in_range) begin
            rsp_load = 1'b1;
            err_d    = 1'b1;
          end else if (!req_user) begin
            rsp_load = 1'b1;
            paddr_d  = req_addr;
          end else if ((in_tens >= MAP_LIMIT) || (req_pid == '0)) begin
            rsp_load = 1'b1;
            err_d    = 1'b1;
          end else begin
            ctx_load = 1'b1;
            state_d  = ST_LOOKUP;
          end
        end
      end
      ST_LOOKUP: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = map_base + ADDR_W'(vpage_q);
        state_d     = ST_WAIT;
      end
      ST_WAIT: begin
        rsp_load = 1'b1;
        if (ent_swapped) begin
          fault_d  = 1'b1;
          vpage_d  = vpage_q;
          victim_d = oldest_base;
          state_d  = ST_FAULT;
        end else if (ent_bad) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          paddr_d = ent_base + ADDR_W'(units_q);
          state_d = ST_IDLE;
        end
      end
      ST_FAULT: begin
        if (fault_done) begin
          ring_adv = 1'b1;
          state_d  = ST_LOOKUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_load;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vpage_q <= '0;
      units_q <= '0;
      pid_q   <= '0;
    end else if (ctx_load) begin
      vpage_q <= in_tens;
      units_q <= in_units;
      pid_q   <= req_pid;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_paddr  <= '0;
      rsp_fault  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_vpage  <= '0;
      rsp_victim <= '0;
    end else if (rsp_load) begin
      rsp_paddr  <= paddr_d;
      rsp_fault  <= fault_d;
      rsp_err    <= err_d;
      rsp_vpage  <= vpage_d;
      rsp_victim <= victim_d;
    end
  end

  // R1
  kern_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (accept && !req_user && in_range) |=>
      (rsp_valid && !rsp_err && !rsp_fault && rsp_paddr == $past(req_addr)));
  // R10
  single_rsp_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |=> !rsp_valid);
  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_rd_en |=> !mem_rd_en);
  // R5
  fault_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && rsp_fault && !$past(fault_done)) |-> !req_ready);
  // R2
  range_err_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (accept && !in_range) |=> (rsp_valid && rsp_err));
endmodule

// File: tb/sim_dec_page_xlate.sv
module sim_dec_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_addr = '0;
  logic        req_user = 1'b0;
  logic [1:0]  req_pid = '0;
  logic        mem_rd_en;
  logic [6:0]  mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic        fault_done = 1'b0;
  logic        rsp_valid;
  logic [6:0]  rsp_paddr;
  logic        rsp_fault;
  logic [3:0]  rsp_vpage;
  logic [6:0]  rsp_victim;
  logic        rsp_err;

  logic [15:0] mem [0:99];
  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  dec_page_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_user(req_user), .req_pid(req_pid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .fault_done(fault_done), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_vpage(rsp_vpage), .rsp_victim(rsp_victim),
    .rsp_err(rsp_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a request; returns at the falling edge after the accepting edge
  task automatic send(input int a, input bit u, input int p);
    chk("R10 ready before request", int'(req_ready), 1);
    req_addr  = 7'(a);
    req_user  = u;
    req_pid   = 2'(p);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // response due one cycle after acceptance
  task automatic expect_quick(input string req, input int paddr, input bit err);
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " rsp_err"}, int'(rsp_err), int'(err));
    chk({req, " rsp_fault"}, int'(rsp_fault), 0);
    chk({req, " no read"}, int'(mem_rd_en), 0);
    if (!err) chk({req, " rsp_paddr"}, int'(rsp_paddr), paddr);
    @(negedge clk);
    chk("R10 pulse ends", int'(rsp_valid), 0);
    chk("R10 ready again", int'(req_ready), 1);
  endtask

  // read cycle, then empty cycle; returns in the response cycle
  task automatic expect_lookup(input string req, input int rd_addr);
    chk({req, " read strobe"}, int'(mem_rd_en), 1);
    chk({req, " read address"}, int'(mem_rd_addr), rd_addr);
    chk("R10 busy", int'(req_ready), 0);
    @(negedge clk);
    chk({req, " no early rsp"}, int'(rsp_valid), 0);
    chk("R4 single read", int'(mem_rd_en), 0);
    @(negedge clk);
  endtask

  task automatic expect_xlate(input string req, input int paddr);
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " rsp_err"}, int'(rsp_err), 0);
    chk({req, " rsp_fault"}, int'(rsp_fault), 0);
    chk({req, " rsp_paddr"}, int'(rsp_paddr), paddr);
    @(negedge clk);
    chk("R10 pulse ends", int'(rsp_valid), 0);
    chk("R10 ready again", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk("R9 ready", int'(req_ready), 1);
    chk("R9 rsp_valid", int'(rsp_valid), 0);
    chk("R9 mem_rd_en", int'(mem_rd_en), 0);
  endtask

  task automatic t_kernel();
    send(43, 0, 1); expect_quick("R1 kernel 43", 43, 0);
    send(99, 0, 0); expect_quick("R1 kernel 99", 99, 0);
    send(0, 0, 2);  expect_quick("R1 kernel 0", 0, 0);
  endtask

  task automatic t_range();
    send(100, 0, 1); expect_quick("R2 kernel 100", 0, 1);
    send(127, 1, 1); expect_quick("R2 user 127", 0, 1);
  endtask

  task automatic t_translate();
    mem[44] = 16'd90;
    send(43, 1, 1); expect_lookup("R4 pid1 page4", 44); expect_xlate("R3 43->93", 93);
    mem[50] = 16'd70;
    send(5, 1, 2);  expect_lookup("R4 pid2 page0", 50); expect_xlate("R3 5->75", 75);
    mem[67] = 16'd0;
    send(79, 1, 3); expect_lookup("R4 pid3 page7", 67); expect_xlate("R3 79->9", 9);
  endtask

  task automatic t_state_pages();
    send(85, 1, 1); expect_quick("R7 page 8", 0, 1);
    send(90, 1, 2); expect_quick("R7 page 9", 0, 1);
    send(12, 1, 0); expect_quick("R11 pid 0", 0, 1);
  endtask

  task automatic t_malformed();
    mem[41] = 16'd95;
    send(17, 1, 1); expect_lookup("R8 entry 95", 41);
    chk("R8 err 95", int'(rsp_err), 1); chk("R8 no fault 95", int'(rsp_fault), 0);
    @(negedge clk);
    mem[42] = 16'd33;
    send(28, 1, 1); expect_lookup("R8 entry 33", 42);
    chk("R8 err 33", int'(rsp_err), 1); chk("R8 no fault 33", int'(rsp_fault), 0);
    @(negedge clk);
  endtask

  task automatic t_faults();
    int victims [4] = '{70, 80, 90, 70};
    foreach (victims[i]) begin
      mem[46] = 16'hFFFF;
      send(61, 1, 1); expect_lookup("R5 fault lookup", 46);
      chk("R5 rsp_valid", int'(rsp_valid), 1);
      chk("R5 rsp_fault", int'(rsp_fault), 1);
      chk("R5 rsp_vpage", int'(rsp_vpage), 6);
      chk("R6 R9 victim", int'(rsp_victim), victims[i]);
      @(negedge clk);
      chk("R5 held busy", int'(req_ready), 0);
      chk("R10 no repeat", int'(rsp_valid), 0);
      mem[46] = 16'(victims[i]);
      fault_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fault_done = 1'b0;
      expect_lookup("R6 replay", 46);
      expect_xlate("R6 replay result", victims[i] + 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100; i++) mem[i] = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_kernel();
    t_range();
    t_translate();
    t_state_pages();
    t_malformed();
    t_faults();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule